// File: doc/BRIEF.md
# Indexed Non-Volatile Configuration RAM with Range Protection

This block puts a 256-byte configuration store behind a handful of byte-wide host ports. The store has two 128-byte halves. The lower half, locations 0x00 to 0x7F, is reached by writing a pointer to one port and then moving data through a companion data port. The upper half, locations 0x80 to 0xFF, has its own pointer and data port pair. The write to the lower pointer port also carries a flag in its top bit. That flag does not take part in addressing and is driven out as an interrupt-enable signal for a non-maskable interrupt.

Software can seal parts of the store. Two strobe ports each freeze one fixed 16-byte span of the lower half against later writes, and reads of a frozen span still work. A lock port accumulates four bits. Each bit shuts off one 32-byte window of the upper half, so that writes to it are dropped and reads of it return a fill value. Software cannot undo any of this sealing; only reset clears it. The storage stands in for a battery-backed array, so reset leaves its contents alone. Location 0x0D always reports its top bit as set, which marks the contents as valid.

Top module: `cmos_nvram`

## Requirements
- R1: A write to port 0 loads bits 6:0 as the lower pointer. A write to port 1 stores the byte at that lower location, and a read of port 1 returns it.
- R2: Bit 7 of a port-0 write is held as `nmi_en` from the next cycle on. It never changes which location is addressed, so pointer values 0x85 and 0x05 select the same byte.
- R3: After any write to port 4, port-1 writes to locations 0x20 to 0x2F are dropped. Reads of those locations still return their stored bytes, and neighbouring locations such as 0x1F and 0x30 remain writable.
- R4: After any write to port 5, port-1 writes to locations 0x30 to 0x3F are dropped, with the same read behaviour as in R3.
- R5: A write to port 6 ORs its bits 3:0 into a lock field and ignores bits 7:4. A read of port 6 returns the lock field in bits 3:0 and zeros above. When lock bit k is set, the upper window 0x80+32k to 0x9F+32k drops port-3 writes, and port-3 reads return 0xFF.
- R6: Lock bits and span protection cannot be cleared by any port write. For example, writing 0x00 to port 6 keeps every lock bit that is already set.
- R7: A read through port 1 of location 0x0D always returns bit 7 as 1. The other bits hold the stored value.
- R8: Reset clears both pointers, `nmi_en`, `bus_rdata`, span protection and lock bits. Reset leaves the stored bytes unchanged.
- R9: A read of port 0 returns {nmi flag, lower pointer}. A read of port 2 returns {0, upper pointer}. Port 2 writes set the upper pointer to location 0x80 + bits 6:0. Reads of ports 4, 5 and 7 return 0x00.
- R10: Read data appears on `bus_rdata` in the cycle after the read access. It holds steady through every later cycle that has no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Host access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_port | input | 3 | Port select 0..7 |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| nmi_en | output | 1 | Held interrupt-enable flag from the lower pointer write |

## Verification
Every lower location is first written with an address-derived byte and read back. This separates correct pointer decoding from aliasing, and the forced valid bit at 0x0D from stored data. The full sweep is repeated with an inverted pattern after each protection strobe. Only the sealed span should keep the old bytes, so an off-by-one span edge or a swapped span shows up. The upper half is swept with a sparse lock mask, then after a zero write to the lock port, then with the complement mask. This tells window decoding apart from lock stickiness and from fill-on-read. A final reset sweep shows that sealing clears while the contents survive.

// File: rtl/cmos_nvram_pkg.sv
package cmos_nvram_pkg;

    typedef enum logic [2:0] {
        PORT_PTR_LO  = 3'd0,
        PORT_DAT_LO  = 3'd1,
        PORT_PTR_HI  = 3'd2,
        PORT_DAT_HI  = 3'd3,
        PORT_SEAL_A  = 3'd4,
        PORT_SEAL_B  = 3'd5,
        PORT_LOCK    = 3'd6,
        PORT_SPARE   = 3'd7
    } port_e;

    typedef struct packed {
        logic ptr_lo_wr;
        logic dat_lo_wr;
        logic dat_lo_rd;
        logic ptr_hi_wr;
        logic dat_hi_wr;
        logic dat_hi_rd;
        logic seal_a_wr;
        logic seal_b_wr;
        logic lock_wr;
    } access_t;

endpackage

// File: rtl/cmos_port_decode.sv
module cmos_port_decode
    import cmos_nvram_pkg::*;
(
    input  logic          cs,
    input  logic          we,
    input  logic [2:0]    port,
    output access_t       acc,
    output logic          rd_any
);

    always_comb begin
        acc    = '0;
        rd_any = cs && !we;
        if (cs) begin
            case (port_e'(port))
                PORT_PTR_LO: acc.ptr_lo_wr = we;
                PORT_DAT_LO: begin
                    acc.dat_lo_wr = we;
                    acc.dat_lo_rd = !we;
                end
                PORT_PTR_HI: acc.ptr_hi_wr = we;
                PORT_DAT_HI: begin
                    acc.dat_hi_wr = we;
                    acc.dat_hi_rd = !we;
                end
                PORT_SEAL_A: acc.seal_a_wr = we;
                PORT_SEAL_B: acc.seal_b_wr = we;
                PORT_LOCK:   acc.lock_wr   = we;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/cmos_guard.sv
module cmos_guard #(
    parameter int AW          = 7,
    parameter int LOCK_N      = 4,
    parameter int SEAL_A_BASE = 32,
    parameter int SEAL_B_BASE = 48,
    parameter int SEAL_SPAN   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seal_a_set,
    input  logic              seal_b_set,
    input  logic              lock_set,
    input  logic [LOCK_N-1:0] lock_bits,
    input  logic [AW-1:0]     lo_ptr,
    input  logic [AW-1:0]     hi_ptr,
    output logic              lo_wr_ok,
    output logic              hi_open,
    output logic [LOCK_N-1:0] lock_q
);

    localparam int WIN_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
    localparam logic [AW-1:0] A_FIRST = AW'(SEAL_A_BASE);
    localparam logic [AW-1:0] A_LAST  = AW'(SEAL_A_BASE + SEAL_SPAN - 1);
    localparam logic [AW-1:0] B_FIRST = AW'(SEAL_B_BASE);
    localparam logic [AW-1:0] B_LAST  = AW'(SEAL_B_BASE + SEAL_SPAN - 1);

    typedef struct packed {
        logic              seal_a;
        logic              seal_b;
        logic [LOCK_N-1:0] lock;
    } guard_t;

    guard_t st_d, st_q;
    logic in_a, in_b;
    logic [WIN_W-1:0] win;

    always_comb begin
        st_d = st_q;
        if (seal_a_set) st_d.seal_a = 1'b1;
        if (seal_b_set) st_d.seal_b = 1'b1;
        if (lock_set)   st_d.lock   = st_q.lock | lock_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        in_a     = (lo_ptr >= A_FIRST) && (lo_ptr <= A_LAST);
        in_b     = (lo_ptr >= B_FIRST) && (lo_ptr <= B_LAST);
        lo_wr_ok = !((in_a && st_q.seal_a) || (in_b && st_q.seal_b));
        win      = hi_ptr[AW-1 -: WIN_W];
        hi_open  = !st_q.lock[win];
        lock_q   = st_q.lock;
    end

    // R6: sealing never falls back without reset
    p_seal_a_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seal_a |=> st_q.seal_a);
    p_seal_b_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seal_b |=> st_q.seal_b);
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock != '0) |=> ((st_q.lock & $past(st_q.lock)) == $past(st_q.lock)));

endmodule

// File: rtl/cmos_ram_array.sv
module cmos_ram_array #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW:0]   addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 2 ** (AW + 1);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    always_comb rdata = mem_q[addr];

    // R1: an accepted write lands at the addressed byte
    p_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/cmos_nvram.sv
module cmos_nvram
    import cmos_nvram_pkg::*;
#(
    parameter int             DW          = 8,
    parameter int             LOCK_N      = 4,
    parameter int             SEAL_A_BASE = 32,
    parameter int             SEAL_B_BASE = 48,
    parameter int             SEAL_SPAN   = 16,
    parameter int             VALID_LOC   = 13,
    parameter int             VALID_BIT   = 7,
    parameter logic [DW-1:0]  LOCKED_FILL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic          bus_we,
    input  logic [2:0]    bus_port,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          nmi_en
);

    localparam int AW = DW - 1;
    localparam logic [AW-1:0] VALID_PTR  = AW'(VALID_LOC);
    localparam logic [DW-1:0] VALID_MASK = DW'(1) << VALID_BIT;

    typedef struct packed {
        logic [AW-1:0] ptr_lo;
        logic [AW-1:0] ptr_hi;
        logic          nmi;
        logic [DW-1:0] rdata;
    } state_t;

    state_t  st_d, st_q;
    access_t acc;
    logic    rd_any;
    logic    lo_wr_ok, hi_open;
    logic [LOCK_N-1:0] lock_q;
    logic          mem_we;
    logic [AW:0]   mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] rd_mux;

    cmos_port_decode u_decode (
        .cs     (bus_cs),
        .we     (bus_we),
        .port   (bus_port),
        .acc    (acc),
        .rd_any (rd_any)
    );

    cmos_guard #(
        .AW          (AW),
        .LOCK_N      (LOCK_N),
        .SEAL_A_BASE (SEAL_A_BASE),
        .SEAL_B_BASE (SEAL_B_BASE),
        .SEAL_SPAN   (SEAL_SPAN)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .seal_a_set (acc.seal_a_wr),
        .seal_b_set (acc.seal_b_wr),
        .lock_set   (acc.lock_wr),
        .lock_bits  (bus_wdata[LOCK_N-1:0]),
        .lo_ptr     (st_q.ptr_lo),
        .hi_ptr     (st_q.ptr_hi),
        .lo_wr_ok   (lo_wr_ok),
        .hi_open    (hi_open),
        .lock_q     (lock_q)
    );

    always_comb begin
        if (acc.dat_hi_wr || acc.dat_hi_rd) mem_addr = {1'b1, st_q.ptr_hi};
        else                                mem_addr = {1'b0, st_q.ptr_lo};
        mem_we = (acc.dat_lo_wr && lo_wr_ok) || (acc.dat_hi_wr && hi_open);
    end

    cmos_ram_array #(
        .AW (AW),
        .DW (DW)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (bus_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        case (port_e'(bus_port))
            PORT_PTR_LO: rd_mux = {st_q.nmi, st_q.ptr_lo};
            PORT_DAT_LO: rd_mux = (st_q.ptr_lo == VALID_PTR) ? (mem_rdata | VALID_MASK)
                                                              : mem_rdata;
            PORT_PTR_HI: rd_mux = {1'b0, st_q.ptr_hi};
            PORT_DAT_HI: rd_mux = hi_open ? mem_rdata : LOCKED_FILL;
            PORT_LOCK:   rd_mux = {{(DW-LOCK_N){1'b0}}, lock_q};
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (acc.ptr_lo_wr) begin
            st_d.ptr_lo = bus_wdata[AW-1:0];
            st_d.nmi    = bus_wdata[DW-1];
        end
        if (acc.ptr_hi_wr) st_d.ptr_hi = bus_wdata[AW-1:0];
        if (rd_any)        st_d.rdata  = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign nmi_en    = st_q.nmi;

    // R2: flag follows top bit of the lower pointer write
    p_nmi_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc.ptr_lo_wr |=> (nmi_en == $past(bus_wdata[DW-1])));

    // R5: a locked window reads as fill
    p_lock_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.dat_hi_rd && !hi_open) |=> (bus_rdata == LOCKED_FILL));

    // R7: valid marker always set on read of the marker byte
    p_valid_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.dat_lo_rd && (st_q.ptr_lo == VALID_PTR)) |=> bus_rdata[VALID_BIT]);

    // R10: read data holds with no read access
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(bus_rdata));

endmodule

// File: tb/cmos_nvram_tb.sv
`timescale 1ns/1ps
module cmos_nvram_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_port = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       nmi_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    cmos_nvram dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_port  (bus_port),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .nmi_en    (nmi_en)
    );

    function automatic logic [7:0] pat1(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] pat2(int a);
        return ~pat1(a);
    endfunction
    function automatic logic [7:0] pat3(int a);
        return 8'((a * 13 + 200) & 255);
    endfunction
    function automatic logic [7:0] pat4(int a);
        return 8'((a ^ 8'h3C) & 255);
    endfunction
    function automatic logic [7:0] mark(int a, logic [7:0] v);
        return (a == 13) ? (v | 8'h80) : v;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] p, logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_port = p; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [2:0] p, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_port = p;
        @(negedge clk);
        bus_cs = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        do_reset();
        // R8: reset state
        chk("R8 rdata", bus_rdata, 8'h00);
        chk("R8 nmi", {7'd0, nmi_en}, 8'h00);
        bus_rd(3'd0, r); chk("R8 ptr", r, 8'h00);
        bus_rd(3'd6, r); chk("R8 lock", r, 8'h00);

        // R1 R2: fill lower half, flag toggles with pointer bit 7
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd0, 8'(a) | ((a & 1) != 0 ? 8'h80 : 8'h00));
            if (a < 4) chk("R2 nmi", {7'd0, nmi_en}, 8'(a & 1));
            bus_wr(3'd1, pat1(a));
        end
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd0, 8'(a));
            bus_rd(3'd1, r);
            chk("R1 R7 lower readback", r, mark(a, pat1(a)));
        end
        // R2 R9: pointer with flag addresses same byte
        bus_wr(3'd0, 8'h85);
        chk("R2 nmi set", {7'd0, nmi_en}, 8'h01);
        bus_rd(3'd0, r); chk("R9 ptr readback", r, 8'h85);
        bus_rd(3'd1, r); chk("R2 no alias", r, pat1(5));
        // R10: hold across write and idle
        bus_wr(3'd0, 8'h07);
        repeat (3) @(negedge clk);
        chk("R10 hold", bus_rdata, pat1(5));
        bus_rd(3'd4, r); chk("R9 seal port read", r, 8'h00);
        bus_rd(3'd7, r); chk("R9 spare port read", r, 8'h00);

        // R3: seal span A, rewrite all
        bus_wr(3'd4, 8'h00);
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd0, 8'(a));
            bus_wr(3'd1, pat2(a));
        end
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd0, 8'(a));
            bus_rd(3'd1, r);
            chk("R3 span A", r, mark(a, (a >= 32 && a < 48) ? pat1(a) : pat2(a)));
        end
        // R4: seal span B, rewrite all
        bus_wr(3'd5, 8'hFF);
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd0, 8'(a));
            bus_wr(3'd1, pat1(a));
        end
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd0, 8'(a));
            bus_rd(3'd1, r);
            chk("R4 span B", r, mark(a, (a >= 48 && a < 64) ? pat2(a) : pat1(a)));
        end

        // R5: upper half baseline
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd2, 8'(a) | 8'h80);
            bus_wr(3'd3, pat3(a));
        end
        bus_rd(3'd2, r); chk("R9 upper ptr", r, 8'h7F);
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd2, 8'(a));
            bus_rd(3'd3, r);
            chk("R5 upper readback", r, pat3(a));
        end
        bus_wr(3'd6, 8'hF5);
        bus_rd(3'd6, r); chk("R5 lock field", r, 8'h05);
        bus_wr(3'd6, 8'h00);
        bus_rd(3'd6, r); chk("R6 lock sticky", r, 8'h05);
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd2, 8'(a));
            bus_wr(3'd3, pat4(a));
        end
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd2, 8'(a));
            bus_rd(3'd3, r);
            chk("R5 R6 windows", r, (((a >> 5) & 1) == 0) ? 8'hFF : pat4(a));
        end
        bus_wr(3'd6, 8'h0A);
        bus_rd(3'd6, r); chk("R5 lock all", r, 8'h0F);
        for (int a = 0; a < 128; a += 17) begin
            bus_wr(3'd2, 8'(a));
            bus_rd(3'd3, r);
            chk("R5 all locked", r, 8'hFF);
        end

        // R8: reset clears sealing, keeps contents
        do_reset();
        chk("R8 nmi after", {7'd0, nmi_en}, 8'h00);
        bus_rd(3'd0, r); chk("R8 ptr after", r, 8'h00);
        bus_rd(3'd2, r); chk("R8 upper ptr after", r, 8'h00);
        bus_rd(3'd6, r); chk("R8 lock after", r, 8'h00);
        for (int a = 32; a < 64; a++) begin
            bus_wr(3'd0, 8'(a));
            bus_wr(3'd1, pat3(a));
            bus_rd(3'd1, r);
            chk("R8 unsealed", r, pat3(a));
        end
        for (int a = 0; a < 128; a++) begin
            bus_wr(3'd2, 8'(a));
            bus_rd(3'd3, r);
            chk("R8 retained", r, (((a >> 5) & 1) == 0) ? pat3(a) : pat4(a));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule